// File: doc/BRIEF.md
# X.21 Receive Character-Condition Detector

This block sits on the receive side of a serial channel running in X.21 mode, after bit assembly. Each time a received character is presented with its strobe, the block classifies it against seven conditions: three host-programmable compare values, the all-zeros pattern, the all-ones pattern, the alternating pattern, and a programmable SYN value. A condition is reported as a 3-bit code in a host-readable status byte only when two consecutive characters classify to the same condition. After a report, the pair search starts again from scratch.

The same status byte carries the state of the X.21 indication lead, which arrives on an active-low asynchronous input and passes through a flop synchronizer. It also carries a sticky lead-change flag, an overrun flag and a parity-error flag. An interrupt request is raised while any event field of the status byte is nonzero. The host clears or sets fields by writing the status byte through a small write port. The same port loads the compare and SYN values.

Top module: `x21_rx_cond_det`

## Requirements
- R1: A nonzero detect code is written into status bits 6:4 only on the clock edge that accepts the second of two consecutive valid characters with the same nonzero class. A single matching character leaves the code unchanged, and so does a pair broken by a character of a different class. A reported code stays in place until a later pair or a host write replaces it.
- R2: The class codes are: 1 compare register 1, 2 compare register 2, 3 compare register 3, 4 all zeros, 5 all ones, 6 alternating, 7 SYN, 0 none. When a character meets several conditions, the lowest code among them is used.
- R3: All zeros means 0x00 and all ones means 0xFF. Alternating means 0x55 or 0xAA. SYN means equal to the SYN register, which resets to 0x16. The compare registers reset to 0x00.
- R4: The status byte is laid out as follows: bit 7 lead on, bits 6:4 detect code, bit 3 overrun, bit 2 parity error, bit 1 constant 0, bit 0 lead change. It reads 0x00 after reset while the lead input is high.
- R5: A pulse on the overrun input sets bit 3. A valid character that carries a parity error sets bit 2. Both flags are sticky.
- R6: Bit 7 reads 1 when the lead input is low (ON) and 0 when it is high (OFF). The input passes through a synchronizer of SYNC_STAGES flops, so the bit follows the pin SYNC_STAGES edges later.
- R7: Bit 0 is set on every change of the synchronized lead value. It stays set until a host write to the status byte clears it.
- R8: After a pair has been reported, the search restarts. A third identical character alone does not produce a new report, and a fourth one does.
- R9: irq is high exactly when the detect code is nonzero or any of bits 3, 2 or 0 is set. It is low on the cycle after the host writes zeros to those fields while no event arrives.
- R10: A host write with select 0 loads status bits 6:4, 3, 2 and 0 from the write data. Bits 7 and 1 of the write data are ignored. An event in the same cycle overrides the written value for the fields it sets. Selects 1, 2 and 3 load compare registers 1, 2 and 3, and select 4 loads the SYN register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_vld | input | 1 | Received character strobe |
| chr_data | input | CHAR_W | Received character |
| chr_perr | input | 1 | Parity error of the strobed character |
| chr_ovr | input | 1 | Pulse: a character was lost because the buffer was full |
| lead_n | input | 1 | X.21 indication lead, active low, asynchronous |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 3 | Write target: 0 status, 1..3 compare, 4 SYN |
| host_wdata | input | 8 | Host write data |
| stat_byte | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CHAR_W = 8 and SYNC_STAGES = 2. At this width every possible character value can be sent as a pair and compared against an arithmetic model of the class priority. The sweep is repeated under register settings that make the compare values collide with the fixed patterns and with SYN, so every priority step is exercised. Lead timing, sticky flags, host writes racing events, and the restart rule are driven directly.

// File: rtl/x21_rx_pkg.sv
package x21_rx_pkg;

  typedef enum logic [2:0] {
    COND_NONE  = 3'd0,
    COND_CMP1  = 3'd1,
    COND_CMP2  = 3'd2,
    COND_CMP3  = 3'd3,
    COND_ZEROS = 3'd4,
    COND_ONES  = 3'd5,
    COND_ALT   = 3'd6,
    COND_SYN   = 3'd7
  } cond_e;

  localparam logic [2:0] SEL_STAT = 3'd0;
  localparam logic [2:0] SEL_CMP1 = 3'd1;
  localparam logic [2:0] SEL_CMP2 = 3'd2;
  localparam logic [2:0] SEL_CMP3 = 3'd3;
  localparam logic [2:0] SEL_SYN  = 3'd4;

endpackage

// File: rtl/x21_char_classify.sv
module x21_char_classify
  import x21_rx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic [CHAR_W-1:0] chr,
  input  logic [CHAR_W-1:0] cmp1,
  input  logic [CHAR_W-1:0] cmp2,
  input  logic [CHAR_W-1:0] cmp3,
  input  logic [CHAR_W-1:0] syn,
  output cond_e             cls
);

  logic [CHAR_W-1:0] alt_hi;
  logic [CHAR_W-1:0] alt_lo;

  // alternating patterns: odd bits set, or even bits set
  for (genvar b = 0; b < CHAR_W; b++) begin : g_alt
    assign alt_hi[b] = (b % 2) == 1;
    assign alt_lo[b] = (b % 2) == 0;
  end

  // priority: compares first, SYN last
  always_comb begin
    if (chr == cmp1)                         cls = COND_CMP1;
    else if (chr == cmp2)                    cls = COND_CMP2;
    else if (chr == cmp3)                    cls = COND_CMP3;
    else if (chr == '0)                      cls = COND_ZEROS;
    else if (chr == '1)                      cls = COND_ONES;
    else if (chr == alt_hi || chr == alt_lo) cls = COND_ALT;
    else if (chr == syn)                     cls = COND_SYN;
    else                                     cls = COND_NONE;
  end

endmodule

// File: rtl/x21_pair_tracker.sv
module x21_pair_tracker
  import x21_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  chr_vld,
  input  cond_e cls,
  output logic  hit,
  output cond_e hit_code
);

  cond_e prev_q, prev_d;
  logic  armed_q, armed_d;

  assign hit      = chr_vld && armed_q && (cls != COND_NONE) && (cls == prev_q);
  assign hit_code = cls;

  always_comb begin
    prev_d  = prev_q;
    armed_d = armed_q;
    if (chr_vld) begin
      if (hit) begin
        // pair reported: the search starts again
        armed_d = 1'b0;
        prev_d  = COND_NONE;
      end else begin
        armed_d = (cls != COND_NONE);
        prev_d  = cls;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= COND_NONE;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R8

endmodule

// File: rtl/x21_lead_sync.sv
module x21_lead_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lead_n,
  output logic lead_on,
  output logic lead_evt
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  // flop 0 samples the pin, each further flop takes its neighbour
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b1;
    else        sync_q[0] <= lead_n;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b1;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= sync_q[LAST];
  end

  assign lead_on  = ~sync_q[LAST];
  assign lead_evt = sync_q[LAST] ^ last_q;

endmodule

// File: rtl/x21_rx_cond_det.sv
module x21_rx_cond_det
  import x21_rx_pkg::*;
#(
  parameter int               CHAR_W      = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CHAR_W-1:0] SYN_INIT   = 8'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_vld,
  input  logic [CHAR_W-1:0] chr_data,
  input  logic              chr_perr,
  input  logic              chr_ovr,
  input  logic              lead_n,
  input  logic              host_wr,
  input  logic [2:0]        host_sel,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        stat_byte,
  output logic              irq
);

  // configuration registers
  logic [CHAR_W-1:0] cmp1_q, cmp2_q, cmp3_q, syn_q;
  logic [CHAR_W-1:0] cmp1_d, cmp2_d, cmp3_d, syn_d;

  // status fields
  logic [2:0] code_q, code_d;
  logic       oe_q, oe_d;
  logic       pe_q, pe_d;
  logic       lchg_q, lchg_d;

  logic  stat_wr;
  cond_e cls;
  logic  hit;
  cond_e hit_code;
  logic  lead_on;
  logic  lead_evt;

  assign stat_wr = host_wr && (host_sel == SEL_STAT);

  x21_char_classify #(.CHAR_W(CHAR_W)) i_classify (
    .chr  (chr_data),
    .cmp1 (cmp1_q),
    .cmp2 (cmp2_q),
    .cmp3 (cmp3_q),
    .syn  (syn_q),
    .cls  (cls)
  );

  x21_pair_tracker i_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .chr_vld  (chr_vld),
    .cls      (cls),
    .hit      (hit),
    .hit_code (hit_code)
  );

  x21_lead_sync #(.SYNC_STAGES(SYNC_STAGES)) i_lead (
    .clk      (clk),
    .rst_n    (rst_n),
    .lead_n   (lead_n),
    .lead_on  (lead_on),
    .lead_evt (lead_evt)
  );

  // next state of the configuration registers
  always_comb begin
    cmp1_d = cmp1_q;
    cmp2_d = cmp2_q;
    cmp3_d = cmp3_q;
    syn_d  = syn_q;
    if (host_wr) begin
      case (host_sel)
        SEL_CMP1: cmp1_d = host_wdata[CHAR_W-1:0];
        SEL_CMP2: cmp2_d = host_wdata[CHAR_W-1:0];
        SEL_CMP3: cmp3_d = host_wdata[CHAR_W-1:0];
        SEL_SYN:  syn_d  = host_wdata[CHAR_W-1:0];
        default:  ;
      endcase
    end
  end

  // next state of the status fields: host write first, events override
  always_comb begin
    code_d = code_q;
    oe_d   = oe_q;
    pe_d   = pe_q;
    lchg_d = lchg_q;
    if (stat_wr) begin
      code_d = host_wdata[6:4];
      oe_d   = host_wdata[3];
      pe_d   = host_wdata[2];
      lchg_d = host_wdata[0];
    end
    if (hit)                 code_d = hit_code;
    if (chr_ovr)             oe_d   = 1'b1;
    if (chr_vld && chr_perr) pe_d   = 1'b1;
    if (lead_evt)            lchg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp1_q <= '0;
      cmp2_q <= '0;
      cmp3_q <= '0;
      syn_q  <= SYN_INIT;
      code_q <= 3'd0;
      oe_q   <= 1'b0;
      pe_q   <= 1'b0;
      lchg_q <= 1'b0;
    end else begin
      cmp1_q <= cmp1_d;
      cmp2_q <= cmp2_d;
      cmp3_q <= cmp3_d;
      syn_q  <= syn_d;
      code_q <= code_d;
      oe_q   <= oe_d;
      pe_q   <= pe_d;
      lchg_q <= lchg_d;
    end
  end

  assign stat_byte = {lead_on, code_q, oe_q, pe_q, 1'b0, lchg_q};
  assign irq       = (code_q != 3'd0) || oe_q || pe_q || lchg_q;

  AST_CODE_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[6:4] != 3'd0 && stat_byte[6:4] != $past(stat_byte[6:4]))
      |-> $past(chr_vld || stat_wr)); // R1

  AST_OVR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    chr_ovr |=> stat_byte[3]); // R5

  AST_LCHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[0] && !stat_wr) |=> stat_byte[0]); // R7

  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && host_wdata[6:2] == 5'd0 && !host_wdata[0] &&
     !chr_vld && !chr_ovr && !lead_evt) |=> !irq); // R9

endmodule

// File: tb/test_x21_rx_cond_det.sv
module test_x21_rx_cond_det;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic          clk;
  logic          rst_n;
  logic          chr_vld;
  logic [CW-1:0] chr_data;
  logic          chr_perr;
  logic          chr_ovr;
  logic          lead_n;
  logic          host_wr;
  logic [2:0]    host_sel;
  logic [7:0]    host_wdata;
  logic [7:0]    stat_byte;
  logic          irq;

  int n_cmp;
  int n_bad;

  logic [7:0] c1, c2, c3, sy;

  x21_rx_cond_det #(.CHAR_W(CW), .SYNC_STAGES(2)) i_x21_rx_cond_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .chr_vld    (chr_vld),
    .chr_data   (chr_data),
    .chr_perr   (chr_perr),
    .chr_ovr    (chr_ovr),
    .lead_n     (lead_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .stat_byte  (stat_byte),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [2:0] model(input logic [7:0] v);
    if (v == c1)                    return 3'd1;
    if (v == c2)                    return 3'd2;
    if (v == c3)                    return 3'd3;
    if (v == 8'h00)                 return 3'd4;
    if (v == 8'hFF)                 return 3'd5;
    if (v == 8'h55 || v == 8'hAA)   return 3'd6;
    if (v == sy)                    return 3'd7;
    return 3'd0;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] v, input logic perr);
    @(negedge clk);
    chr_vld = 1'b1; chr_data = v; chr_perr = perr;
    @(negedge clk);
    chr_vld = 1'b0; chr_perr = 1'b0;
  endtask

  task automatic set_cfg(input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic [7:0] s);
    c1 = a; c2 = b; c3 = c; sy = s;
    host_write(3'd1, a);
    host_write(3'd2, b);
    host_write(3'd3, c);
    host_write(3'd4, s);
  endtask

  // pick a character outside every class of the current settings
  function automatic logic [7:0] neutral();
    for (int k = 1; k < 256; k++)
      if (model(8'(k)) == 3'd0) return 8'(k);
    return 8'h01;
  endfunction

  task automatic sweep(input string tag);
    logic [7:0] nv;
    nv = neutral();
    for (int v = 0; v < 256; v++) begin
      host_write(3'd0, 8'h00);
      send(nv, 1'b0);
      send(8'(v), 1'b0);
      check({tag, " R1 single"}, {1'b0, stat_byte[6:4]}, 8'h00);
      send(8'(v), 1'b0);
      check({tag, " R2 pair"}, {5'd0, stat_byte[6:4]}, {5'd0, model(8'(v))});
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] nv;
    n_cmp = 0; n_bad = 0;
    chr_vld = 0; chr_data = 0; chr_perr = 0; chr_ovr = 0;
    lead_n = 1; host_wr = 0; host_sel = 0; host_wdata = 0;
    c1 = 8'h00; c2 = 8'h00; c3 = 8'h00; sy = 8'h16;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R4 reset status", stat_byte, 8'h00);
    check("R9 reset irq", {7'd0, irq}, 8'h00);

    // R3 reset values: compares 0x00, SYN 0x16
    send(8'h16, 1'b0); send(8'h16, 1'b0);
    check("R3 syn reset", {5'd0, stat_byte[6:4]}, 8'd7);
    host_write(3'd0, 8'h00);
    send(8'h00, 1'b0); send(8'h00, 1'b0);
    check("R3 cmp1 reset", {5'd0, stat_byte[6:4]}, 8'd1);

    // R2 R3 sweeps under distinct settings
    set_cfg(8'h12, 8'h34, 8'h56, 8'h16);
    sweep("plain");
    set_cfg(8'h00, 8'hFF, 8'h55, 8'hAA);
    sweep("overlap");
    set_cfg(8'h3C, 8'h3C, 8'hC3, 8'hFF);
    sweep("dup");

    // R1 broken pair and sticky code
    set_cfg(8'h12, 8'h34, 8'h56, 8'h16);
    nv = neutral();
    host_write(3'd0, 8'h00);
    send(8'h12, 1'b0); send(8'h34, 1'b0); send(8'h12, 1'b0);
    check("R1 broken pair", {5'd0, stat_byte[6:4]}, 8'd0);
    send(8'h12, 1'b0);
    check("R1 pair after break", {5'd0, stat_byte[6:4]}, 8'd1);
    send(nv, 1'b0);
    check("R1 code held", {5'd0, stat_byte[6:4]}, 8'd1);

    // R8 restart after report
    host_write(3'd0, 8'h00);
    send(8'hFF, 1'b0); send(8'hFF, 1'b0);
    check("R8 first pair", {5'd0, stat_byte[6:4]}, 8'd5);
    host_write(3'd0, 8'h00);
    send(8'hFF, 1'b0);
    check("R8 third char", {5'd0, stat_byte[6:4]}, 8'd0);
    send(8'hFF, 1'b0);
    check("R8 fourth char", {5'd0, stat_byte[6:4]}, 8'd5);

    // R5 flags, R9 irq
    host_write(3'd0, 8'h00);
    check("R9 irq clear", {7'd0, irq}, 8'h00);
    send(nv, 1'b1);
    check("R5 parity", stat_byte, 8'h04);
    check("R9 irq parity", {7'd0, irq}, 8'h01);
    send(nv, 1'b0);
    check("R5 parity sticky", stat_byte, 8'h04);
    host_write(3'd0, 8'h00);
    @(negedge clk); chr_ovr = 1; @(negedge clk); chr_ovr = 0;
    check("R5 overrun", stat_byte, 8'h08);
    check("R9 irq overrun", {7'd0, irq}, 8'h01);

    // R10 write racing an event, ignored bits
    @(negedge clk);
    chr_ovr = 1; host_wr = 1; host_sel = 3'd0; host_wdata = 8'h00;
    @(negedge clk);
    chr_ovr = 0; host_wr = 0;
    check("R10 event wins", stat_byte, 8'h08);
    host_write(3'd0, 8'hFF);
    check("R10 write all ones", stat_byte, 8'h7D);
    host_write(3'd0, 8'h00);
    check("R10 write zeros", stat_byte, 8'h00);

    // R6 R7 lead handling
    @(negedge clk); lead_n = 0;
    @(negedge clk);
    check("R6 lead after one edge", {7'd0, stat_byte[7]}, 8'd0);
    @(negedge clk);
    check("R6 lead after two edges", {7'd0, stat_byte[7]}, 8'd1);
    @(negedge clk);
    check("R7 lead change set", stat_byte, 8'h81);
    repeat (3) @(negedge clk);
    check("R7 lead change sticky", stat_byte, 8'h81);
    host_write(3'd0, 8'h00);
    check("R7 lead change cleared", stat_byte, 8'h80);
    check("R9 irq after clear", {7'd0, irq}, 8'h00);
    @(negedge clk); lead_n = 1;
    repeat (4) @(negedge clk);
    check("R7 lead off change", stat_byte, 8'h01);
    check("R9 irq lead change", {7'd0, irq}, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule